// File: doc/BRIEF.md
# Multiplexed Bus Address Latch and Command Decoder

This block sits on the system side of a bus with a single master. The low address lines carry data after the address phase, and the upper address lines carry status bits after it. While the address-latch strobe is high, the block captures the 20-bit address and the byte-high flag. On the first clock after the strobe falls, it takes the two segment-class status bits from the upper lines. It uses them as the two top bits of a 22-bit system address, so each class of access selects its own 1 MB bank.

The block also turns the read strobe, the write strobe and the memory/I/O select into four separate active-low commands: memory read, memory write, I/O read and I/O write. When both strobes are low at once, it raises a protocol-error flag instead of issuing a command. While the master has handed off the bus (hold acknowledge), it issues nothing. The lower and upper byte-lane enables come from the latched A0 and the byte-high flag.

All bus pins are sampled on the rising clock edge. The block has no data stream, so every pin is a plain level signal with no handshake.

Top module: `mux_bus_bridge`

## Requirements
- R1: At each rising edge with `ale_i` high, `{as_i, ad_i}` is stored, and `sys_addr_o[19:0]` shows it after that edge. `as_i` supplies bits 19:16.
- R2: At edges with `ale_i` low, `sys_addr_o[19:0]` and the byte-high flag hold their values, whatever `ad_i` and `as_i` do.
- R3: At the first edge with `ale_i` low after an edge with it high, `as_i[1]` is stored into `sys_addr_o[21]` and `as_i[0]` into `sys_addr_o[20]`. At every other edge these two bits hold.
- R4: One edge after the inputs are sampled, a command output goes low according to the strobe inputs. `rd_n_i`=0 with `wr_n_i`=1 gives a read, and `wr_n_i`=0 with `rd_n_i`=1 gives a write. `mio_i`=1 routes the command to memory and `mio_i`=0 routes it to I/O. Before that edge the outputs keep their previous values.
- R5: At most one of the four command outputs is low at any time.
- R6: Sampling `rd_n_i`=0 and `wr_n_i`=0 together, outside hold, sets `proto_err_o` to 1 and leaves all commands high after the edge. Otherwise `proto_err_o` is 0.
- R7: While `hlda_i`=1 is sampled, all commands are high after the edge and `proto_err_o` is 0, whatever the strobes are.
- R8: `be_lo_o` is 1 when the latched A0 is 0. `be_hi_o` is 1 when the latched byte-high flag (`bhe_n_i`) is 0. Both are 1 for an aligned 16-bit transfer.
- R9: During reset, the address is 0 and the byte-high flag is 1, so `be_lo_o`=1 and `be_hi_o`=0. All commands are high and `proto_err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ale_i | input | 1 | Address-latch strobe, active high |
| ad_i | input | 16 | Multiplexed address/data lines A15..A0 |
| as_i | input | 4 | Multiplexed address/status lines A19..A16 / S6..S3 |
| bhe_n_i | input | 1 | Byte-high flag, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| mio_i | input | 1 | 1 = memory, 0 = I/O |
| hlda_i | input | 1 | Hold acknowledge, bus released |
| sys_addr_o | output | 22 | Bank bits 21:20 and latched address 19:0 |
| be_lo_o | output | 1 | Lower byte lane enable |
| be_hi_o | output | 1 | Upper byte lane enable |
| mem_rd_n_o | output | 1 | Memory read command, active low |
| mem_wr_n_o | output | 1 | Memory write command, active low |
| io_rd_n_o | output | 1 | I/O read command, active low |
| io_wr_n_o | output | 1 | I/O write command, active low |
| proto_err_o | output | 1 | Both strobes low at once |

## Verification
Every result here is due exactly one rising edge after the inputs are sampled. The bench drives pins on the falling edge and reads results on the next falling edge. The address is visible after the edge with the strobe high. The bank bits follow one edge later, at the first edge with the strobe low. Commands and the error flag appear after the edge that samples the strobes. For commands, the bench also reads the outputs just after driving new strobes, before the edge, to confirm that nothing has changed early. The byte enables follow the latched address combinationally, so they are read on the same falling edge as the address.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;
  localparam int NUM_CMD  = 4;
  localparam int IDX_MRD  = 0;
  localparam int IDX_MWR  = 1;
  localparam int IDX_IORD = 2;
  localparam int IDX_IOWR = 3;

  typedef struct packed {
    logic [NUM_CMD-1:0] hot;
    logic               err;
  } cmd_dec_t;

  function automatic cmd_dec_t decode_cmd(input logic rd_n, input logic wr_n,
                                          input logic mem_sel, input logic hold);
    cmd_dec_t d;
    d.hot = '0;
    d.err = 1'b0;
    if (!hold) begin
      if (!rd_n && !wr_n) d.err = 1'b1;
      else if (!rd_n) d.hot[mem_sel ? IDX_MRD : IDX_IORD] = 1'b1;
      else if (!wr_n) d.hot[mem_sel ? IDX_MWR : IDX_IOWR] = 1'b1;
    end
    return d;
  endfunction
endpackage

// File: rtl/addr_latch.sv
module addr_latch #(
  parameter int AD_W = 16,
  parameter int AS_W = 4,
  localparam int ADDR_W = AD_W + AS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale_i,
  input  logic [AD_W-1:0]   ad_i,
  input  logic [AS_W-1:0]   as_i,
  input  logic              bhe_n_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              be_lo_o,
  output logic              be_hi_o
);
  logic [ADDR_W-1:0] addr_q;
  logic              bhe_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      bhe_n_q <= 1'b1;
    end else if (ale_i) begin
      addr_q  <= {as_i, ad_i};
      bhe_n_q <= bhe_n_i;
    end
  end

  assign addr_o  = addr_q;
  assign be_lo_o = ~addr_q[0];
  assign be_hi_o = ~bhe_n_q;

  p_addr_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ale_i |=> addr_q == $past({as_i, ad_i}));
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ale_i |=> ($stable(addr_q) && $stable(bhe_n_q)));
endmodule

// File: rtl/bank_capture.sv
module bank_capture #(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale_i,
  input  logic [BANK_W-1:0] st_i,
  output logic [BANK_W-1:0] bank_o
);
  logic              ale_d;
  logic [BANK_W-1:0] bank_q;
  logic              ale_fall;

  assign ale_fall = ale_d && !ale_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_d  <= 1'b0;
      bank_q <= '0;
    end else begin
      ale_d <= ale_i;
      if (ale_fall) bank_q <= st_i;
    end
  end

  assign bank_o = bank_q;

  p_bank_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ale_i) && !ale_i) |=> bank_q == $past(st_i));
  p_bank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(ale_i) && !ale_i) |=> $stable(bank_q));
endmodule

// File: rtl/cmd_decode.sv
module cmd_decode
  import mux_bus_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_n_i,
  input  logic               wr_n_i,
  input  logic               mio_i,
  input  logic               hlda_i,
  output logic [NUM_CMD-1:0] cmd_n_o,
  output logic               err_o
);
  cmd_dec_t dec;
  logic [NUM_CMD-1:0] hot_q;
  logic               err_q;

  assign dec = decode_cmd(rd_n_i, wr_n_i, mio_i, hlda_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hot_q <= '0;
      err_q <= 1'b0;
    end else begin
      hot_q <= dec.hot;
      err_q <= dec.err;
    end
  end

  for (genvar i = 0; i < NUM_CMD; i++) begin : g_cmd
    assign cmd_n_o[i] = ~hot_q[i];
  end
  assign err_o = err_q;

  p_mem_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n_i && wr_n_i && mio_i && !hlda_i) |=> !cmd_n_o[IDX_MRD]);
  p_io_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n_i && !wr_n_i && !mio_i && !hlda_i) |=> !cmd_n_o[IDX_IOWR]);
  p_single_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cmd_n_o) <= 1);
  p_conflict_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n_i && !wr_n_i && !hlda_i) |=> (err_o && (&cmd_n_o)));
  p_hold_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hlda_i |=> ((&cmd_n_o) && !err_o));
endmodule

// File: rtl/mux_bus_bridge.sv
module mux_bus_bridge
  import mux_bus_pkg::*;
#(
  parameter int AD_W   = 16,
  parameter int AS_W   = 4,
  parameter int BANK_W = 2,
  localparam int ADDR_W = AD_W + AS_W,
  localparam int SYS_W  = ADDR_W + BANK_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ale_i,
  input  logic [AD_W-1:0]  ad_i,
  input  logic [AS_W-1:0]  as_i,
  input  logic             bhe_n_i,
  input  logic             rd_n_i,
  input  logic             wr_n_i,
  input  logic             mio_i,
  input  logic             hlda_i,
  output logic [SYS_W-1:0] sys_addr_o,
  output logic             be_lo_o,
  output logic             be_hi_o,
  output logic             mem_rd_n_o,
  output logic             mem_wr_n_o,
  output logic             io_rd_n_o,
  output logic             io_wr_n_o,
  output logic             proto_err_o
);
  logic [ADDR_W-1:0]  addr;
  logic [BANK_W-1:0]  bank;
  logic [NUM_CMD-1:0] cmd_n;

  addr_latch #(.AD_W(AD_W), .AS_W(AS_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .ale_i(ale_i), .ad_i(ad_i), .as_i(as_i),
    .bhe_n_i(bhe_n_i), .addr_o(addr), .be_lo_o(be_lo_o), .be_hi_o(be_hi_o)
  );

  bank_capture #(.BANK_W(BANK_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .ale_i(ale_i), .st_i(as_i[BANK_W-1:0]),
    .bank_o(bank)
  );

  cmd_decode u_cmd (
    .clk(clk), .rst_n(rst_n), .rd_n_i(rd_n_i), .wr_n_i(wr_n_i),
    .mio_i(mio_i), .hlda_i(hlda_i), .cmd_n_o(cmd_n), .err_o(proto_err_o)
  );

  assign sys_addr_o = {bank, addr};
  assign mem_rd_n_o = cmd_n[IDX_MRD];
  assign mem_wr_n_o = cmd_n[IDX_MWR];
  assign io_rd_n_o  = cmd_n[IDX_IORD];
  assign io_wr_n_o  = cmd_n[IDX_IOWR];
endmodule

// File: tb/mux_bus_bridge_tb.sv
module mux_bus_bridge_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic ale, bhe_n, rd_n, wr_n, mio, hlda;
  logic [15:0] ad;
  logic [3:0]  as_s;
  logic [21:0] sys_addr;
  logic be_lo, be_hi, mrd_n, mwr_n, iord_n, iowr_n, perr;
  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_bus_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .ale_i(ale), .ad_i(ad), .as_i(as_s),
    .bhe_n_i(bhe_n), .rd_n_i(rd_n), .wr_n_i(wr_n), .mio_i(mio),
    .hlda_i(hlda), .sys_addr_o(sys_addr), .be_lo_o(be_lo), .be_hi_o(be_hi),
    .mem_rd_n_o(mrd_n), .mem_wr_n_o(mwr_n), .io_rd_n_o(iord_n),
    .io_wr_n_o(iowr_n), .proto_err_o(perr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {mrd_n, mwr_n, iord_n, iowr_n, perr};
  endfunction

  task automatic t_reset();
    chk("R9 addr", 32'(sys_addr), 32'h0);
    chk("R9 lanes", {30'd0, be_lo, be_hi}, 32'h2);
    chk("R9 cmds", 32'(outs()), 32'h1E);
  endtask

  task automatic t_addr_phase(input logic [19:0] a, input logic bh,
                              input logic [1:0] seg, input logic [1:0] lanes);
    @(negedge clk);
    ale = 1'b1; ad = a[15:0]; as_s = a[19:16]; bhe_n = bh;
    @(negedge clk);
    chk("R1 capture", 32'(sys_addr[19:0]), 32'(a));
    chk("R8 lanes", {30'd0, be_lo, be_hi}, 32'(lanes));
    ale = 1'b0; ad = ~a[15:0]; as_s = {2'b01, seg}; bhe_n = ~bh;
    @(negedge clk);
    chk("R3 bank", 32'(sys_addr[21:20]), 32'(seg));
    chk("R2 hold", 32'(sys_addr[19:0]), 32'(a));
    as_s = {2'b00, ~seg}; ad = 16'h5A5A;
    @(negedge clk);
    chk("R3 bank hold", 32'(sys_addr[21:20]), 32'(seg));
    chk("R2 hold lanes", {30'd0, be_lo, be_hi}, 32'(lanes));
  endtask

  // exp bits: {mrd_n, mwr_n, iord_n, iowr_n, perr}
  task automatic t_cmd(input string req, input logic r, input logic w,
                       input logic m, input logic h, input logic [4:0] exp);
    @(negedge clk);
    rd_n = r; wr_n = w; mio = m; hlda = h;
    #1;
    chk("R4 no early change", 32'(outs()), 32'h1E);
    @(negedge clk);
    chk(req, 32'(outs()), 32'(exp));
    chk("R5 single", 32'($countones(~outs()[4:1]) <= 1), 32'h1);
    rd_n = 1'b1; wr_n = 1'b1; hlda = 1'b0;
    @(negedge clk);
    chk("R4 release", 32'(outs()), 32'h1E);
  endtask

  initial begin
    #(CLK_PERIOD*50000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ale = 1'b0; ad = '0; as_s = '0; bhe_n = 1'b1;
    rd_n = 1'b1; wr_n = 1'b1; mio = 1'b1; hlda = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_addr_phase(20'hABCD4, 1'b0, 2'b11, 2'b11);
    t_addr_phase(20'h12345, 1'b0, 2'b10, 2'b01);
    t_addr_phase(20'hF0F08, 1'b1, 2'b01, 2'b10);
    t_addr_phase(20'h00002, 1'b1, 2'b00, 2'b10);
    t_cmd("R4 mem read",  1'b0, 1'b1, 1'b1, 1'b0, 5'b01110);
    t_cmd("R4 mem write", 1'b1, 1'b0, 1'b1, 1'b0, 5'b10110);
    t_cmd("R4 io read",   1'b0, 1'b1, 1'b0, 1'b0, 5'b11010);
    t_cmd("R4 io write",  1'b1, 1'b0, 1'b0, 1'b0, 5'b11100);
    t_cmd("R6 conflict",  1'b0, 1'b0, 1'b1, 1'b0, 5'b11111);
    t_cmd("R7 hold read", 1'b0, 1'b1, 1'b1, 1'b1, 5'b11110);
    t_cmd("R7 hold both", 1'b0, 1'b0, 1'b0, 1'b1, 5'b11110);
    t_cmd("R6 idle",      1'b1, 1'b1, 1'b0, 1'b0, 5'b11110);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule